// File: doc/BRIEF.md
# Multi-mode logic cell with shared 64-bit storage

This block models one reconfigurable logic element built around a single storage array of 2^ADDR_W bits (64 by default). A mode select decides what that array is. It can be a six-input truth table, or two five-input truth tables that share their address. It can also be a 64x1 memory with a synchronous write and a combinational read. Finally, it can be a 32-stage shift register with an addressable tap, or two independent 16-stage shift registers. Each of the two outputs has its own optional flip-flop stage. A per-output select picks either the combinational value or the registered one.

The storage takes its contents from the initialization vector in two cases: while reset is held, and on any clock edge where the requested mode differs from the active one. On those same edges both output flip-flops clear. Writes and shifts happen only on rising edges with the write enable high. Table reads, memory reads and tap selection are combinational from the address inputs and follow the active mode.

Top module: `flex_lut_cell`

## Requirements
- R1: Mode code 0 is the six-input table: out_o[0] equals storage bit addr_i, and out_o[1] is 0. Codes 5, 6 and 7 are treated as code 0. Switching between code 0 and codes 5 to 7 is therefore not a mode change.
- R2: Mode code 1 is the dual five-input table. out_o[0] equals bit {0,addr_i[4:0]} and out_o[1] equals bit {1,addr_i[4:0]}. addr_i[5] has no effect.
- R3: When oreg_en_i[k] is 1, out_o[k] shows the combinational value of output k as it stood just before the latest rising edge. When oreg_en_i[k] is 0, out_o[k] is that combinational value directly.
- R4: Mode code 2 is the 64x1 memory. On a rising edge with we_i high, bit addr_i takes din_i[0]. out_o[0] reads bit addr_i combinationally, and out_o[1] is 0.
- R5: Mode code 3 is the 32-stage shift register. On an edge with we_i high, bits 31:0 move one place toward the higher index and bit 0 takes din_i[0]; bits 63:32 are not touched. out_o[0] is bit addr_i[4:0], where tap 0 is the newest bit. out_o[1] is bit 31, the cascade output.
- R6: Mode code 4 is the pair of 16-stage shift registers. On an edge with we_i high, half A (bits 15:0) shifts in din_i[0] and half B (bits 47:32) shifts in din_i[1]. In both halves bit 0 of the half is the newest bit. out_o[0] is bit addr_i[3:0] and out_o[1] is bit 32+addr_i[3:0].
- R7: With we_i low, the storage keeps its contents in every mode. In modes 0 and 1, we_i has no effect on the storage.
- R8: While rst is high, the storage loads init_i on each edge and both output flip-flops clear to 0.
- R9: On an edge where the decoded mode_i differs from the active mode, the new mode becomes active. On that edge the storage loads init_i, both output flip-flops clear to 0, and no write or shift takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Requested mode code (0 to 4, with 5 to 7 treated as 0) |
| init_i | input | 2^ADDR_W | Initialization vector loaded at reset and on a mode change |
| addr_i | input | ADDR_W | Address, logic inputs and tap select |
| din_i | input | 2 | Data in: bit 0 for the memory, the 32-stage register and half A; bit 1 for half B |
| we_i | input | 1 | Write or shift enable |
| oreg_en_i | input | 2 | Per-output select of the registered path |
| out_o | output | 2 | Cell outputs |

## Verification
The bench aims at the points where the modes share storage. It checks that addr_i[5] is ignored in the dual-table mode; a design that failed here would read the wrong half. It checks the cascade bit and the two-tap halves of the shift modes; a design with a wrong shift direction or wrong half boundaries would expose its error at tap 0 and at bit 31. It also changes modes partway through a run. Any write that leaked through on the change edge, or any output flip-flop left uncleared, would then show as a wrong bit. Switching between code 0 and codes 5 to 7 must not reload the storage. The bench also pulses the write enable in table mode; a design that treated table mode as a memory would corrupt the table it reads back.

// File: rtl/flex_lut_pkg.sv
package flex_lut_pkg;

  typedef enum logic [2:0] {
    CM_LUT6      = 3'd0,
    CM_LUT5X2    = 3'd1,
    CM_RAM       = 3'd2,
    CM_SHIFT32   = 3'd3,
    CM_SHIFT16X2 = 3'd4
  } cell_mode_e;

  localparam int unsigned N_OUT = 2;

  function automatic cell_mode_e decode_mode(input logic [2:0] raw);
    case (raw)
      3'd1:    return CM_LUT5X2;
      3'd2:    return CM_RAM;
      3'd3:    return CM_SHIFT32;
      3'd4:    return CM_SHIFT16X2;
      default: return CM_LUT6;
    endcase
  endfunction

endpackage

// File: rtl/flex_lut_store.sv
module flex_lut_store
  import flex_lut_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  cell_mode_e        mode,
  input  logic [DEPTH-1:0]  init,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        din,
  input  logic              we,
  output logic [DEPTH-1:0]  mem
);

  localparam int unsigned HALF = DEPTH / 2;
  localparam int unsigned QTR  = DEPTH / 4;

  always_ff @(posedge clk) begin
    if (clr) begin
      mem <= init;
    end else if (we) begin
      case (mode)
        CM_RAM:       mem[addr] <= din[0];
        CM_SHIFT32:   mem[HALF-1:0] <= {mem[HALF-2:0], din[0]};
        CM_SHIFT16X2: begin
          mem[QTR-1:0]         <= {mem[QTR-2:0], din[0]};
          mem[HALF+QTR-1:HALF] <= {mem[HALF+QTR-2:HALF], din[1]};
        end
        default: ;
      endcase
    end
  end

  // R8
  init_load_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> mem == $past(init));

  // R4
  ram_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && we && mode == CM_RAM) |=> mem[$past(addr)] == $past(din[0]));

  // R5
  srl32_upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && mode == CM_SHIFT32) |=> mem[DEPTH-1:HALF] == $past(mem[DEPTH-1:HALF]));

  // R7
  lut_write_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && (mode == CM_LUT6 || mode == CM_LUT5X2)) |=> $stable(mem));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !we) |=> $stable(mem));

endmodule

// File: rtl/flex_lut_read.sv
module flex_lut_read
  import flex_lut_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0]  mem,
  input  cell_mode_e        mode,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_OUT-1:0]  comb
);

  localparam int unsigned HALF = DEPTH / 2;

  logic [ADDR_W-1:0] lo_half_idx, hi_half_idx, a_tap_idx, b_tap_idx;

  assign lo_half_idx = {1'b0, addr[ADDR_W-2:0]};
  assign hi_half_idx = {1'b1, addr[ADDR_W-2:0]};
  assign a_tap_idx   = {2'b00, addr[ADDR_W-3:0]};
  assign b_tap_idx   = {2'b10, addr[ADDR_W-3:0]};

  always_comb begin
    comb = '0;
    case (mode)
      CM_LUT5X2: begin
        comb[0] = mem[lo_half_idx];
        comb[1] = mem[hi_half_idx];
      end
      CM_SHIFT32: begin
        comb[0] = mem[lo_half_idx];
        comb[1] = mem[HALF-1];
      end
      CM_SHIFT16X2: begin
        comb[0] = mem[a_tap_idx];
        comb[1] = mem[b_tap_idx];
      end
      default: comb[0] = mem[addr];
    endcase
  end

endmodule

// File: rtl/flex_lut_oreg.sv
module flex_lut_oreg
  import flex_lut_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [N_OUT-1:0] comb,
  input  logic [N_OUT-1:0] en,
  output logic [N_OUT-1:0] out
);

  logic [N_OUT-1:0] q;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    always_ff @(posedge clk) begin
      if (clr) q[k] <= 1'b0;
      else     q[k] <= comb[k];
    end
    assign out[k] = en[k] ? q[k] : comb[k];
  end

  // R9
  oreg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0);

endmodule

// File: rtl/flex_lut_cell.sv
module flex_lut_cell
  import flex_lut_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_i,
  input  logic [DEPTH-1:0]  init_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        din_i,
  input  logic              we_i,
  input  logic [1:0]        oreg_en_i,
  output logic [1:0]        out_o
);

  cell_mode_e       mode_req, mode_q;
  logic             clr;
  logic [DEPTH-1:0] mem;
  logic [N_OUT-1:0] comb;

  assign mode_req = decode_mode(mode_i);
  assign clr      = rst || (mode_req != mode_q);

  always_ff @(posedge clk) begin
    mode_q <= mode_req;
  end

  flex_lut_store #(.ADDR_W(ADDR_W)) store_i (
    .clk(clk), .rst(rst), .clr(clr), .mode(mode_q), .init(init_i),
    .addr(addr_i), .din(din_i), .we(we_i), .mem(mem)
  );

  flex_lut_read #(.ADDR_W(ADDR_W)) read_i (
    .mem(mem), .mode(mode_q), .addr(addr_i), .comb(comb)
  );

  flex_lut_oreg oreg_i (
    .clk(clk), .rst(rst), .clr(clr), .comb(comb), .en(oreg_en_i), .out(out_o)
  );

endmodule

// File: tb/flex_lut_cell_tb_top.sv
`timescale 1ns/1ps
module flex_lut_cell_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  mode_i;
  logic [63:0] init_i;
  logic [5:0]  addr_i;
  logic [1:0]  din_i;
  logic        we_i;
  logic [1:0]  oreg_en_i;
  logic [1:0]  out_o;

  int n_chk  = 0;
  int n_fail = 0;

  logic [63:0] m;
  logic [2:0]  mq;
  logic [1:0]  qm;

  always #4 clk = ~clk;

  flex_lut_cell dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .init_i(init_i), .addr_i(addr_i),
    .din_i(din_i), .we_i(we_i), .oreg_en_i(oreg_en_i), .out_o(out_o)
  );

  function automatic logic [2:0] eff(input logic [2:0] r);
    return (r > 3'd4) ? 3'd0 : r;
  endfunction

  function automatic logic [1:0] model_comb(input logic [63:0] s,
                                            input logic [2:0] md,
                                            input logic [5:0] a);
    case (md)
      3'd1:    return {s[{1'b1, a[4:0]}], s[{1'b0, a[4:0]}]};
      3'd3:    return {s[31], s[{1'b0, a[4:0]}]};
      3'd4:    return {s[{2'b10, a[3:0]}], s[{2'b00, a[3:0]}]};
      default: return {1'b0, s[a]};
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] md, input logic [1:0] oen);
    if (oen != 2'b00) return "R3";
    case (md)
      3'd1:    return "R2";
      3'd2:    return "R4";
      3'd3:    return "R5";
      3'd4:    return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic step(input logic r, input logic [2:0] md, input logic [63:0] iv,
                      input logic [5:0] a, input logic [1:0] d, input logic w,
                      input logic [1:0] oen, input string tag, input bit chk);
    logic [1:0] c, e;
    @(negedge clk);
    rst = r; mode_i = md; init_i = iv; addr_i = a; din_i = d; we_i = w; oreg_en_i = oen;
    #2;
    c = model_comb(m, mq, a);
    if (chk) begin
      e = (oen & qm) | (~oen & c);
      n_chk++;
      if (out_o !== e) begin
        n_fail++;
        $display("FAIL %s: out_o=%b expected %b (mode %0d addr %0d)", tag, out_o, e, mq, a);
      end
    end
    if (r || eff(md) != mq) begin
      m = iv; mq = eff(md); qm = 2'b00;
    end else begin
      qm = c;
      if (w) begin
        case (mq)
          3'd2: m[a] = d[0];
          3'd3: m[31:0] = {m[30:0], d[0]};
          3'd4: begin
            m[15:0]  = {m[14:0], d[0]};
            m[47:32] = {m[46:32], d[1]};
          end
          default: ;
        endcase
      end
    end
  endtask

  task automatic sweep(input logic [2:0] md, input logic [63:0] iv, input string tag);
    for (int a = 0; a < 64; a++) step(1'b0, md, iv, 6'(a), 2'b00, 1'b0, 2'b00, tag, 1'b1);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] iv;
    logic [2:0]  md;
    void'($urandom(32'd5150));
    iv = 64'hA5C3_0F96_1234_FEDC;
    for (int i = 0; i < 3; i++) step(1'b1, 3'd0, iv, 6'd0, 2'b00, 1'b0, 2'b00, "R8", 1'b0);
    // R8: registered paths cleared after reset
    step(1'b0, 3'd0, iv, 6'd5, 2'b00, 1'b0, 2'b11, "R8", 1'b1);
    sweep(3'd0, iv, "R1");
    // R7: write pulses in table mode leave the table intact
    for (int i = 0; i < 8; i++)
      step(1'b0, 3'd0, iv, 6'(i * 7), 2'b11, 1'b1, 2'b00, "R7", 1'b1);
    sweep(3'd0, iv, "R7");
    // R1: codes 5..7 are the same mode, no reload
    step(1'b0, 3'd6, ~iv, 6'd9, 2'b00, 1'b0, 2'b01, "R1", 1'b1);
    sweep(3'd5, ~iv, "R1");
    // R9: switch to dual table with a new vector
    iv = 64'h0123_4567_89AB_CDEF;
    step(1'b0, 3'd1, iv, 6'd3, 2'b00, 1'b0, 2'b00, "R9", 1'b1);
    step(1'b0, 3'd1, iv, 6'd3, 2'b00, 1'b0, 2'b11, "R9", 1'b1);
    sweep(3'd1, iv, "R2");
    for (int i = 0; i < 8; i++)
      step(1'b0, 3'd1, iv, 6'(i * 9), 2'b01, 1'b1, 2'b00, "R7", 1'b1);
    sweep(3'd1, iv, "R7");
    // directed random per writable mode
    for (int mm = 2; mm <= 4; mm++) begin
      iv = {$urandom, $urandom};
      step(1'b0, 3'(mm), iv, 6'd0, 2'b11, 1'b1, 2'b11, "R9", 1'b1);
      step(1'b0, 3'(mm), iv, 6'd0, 2'b11, 1'b1, 2'b11, "R9", 1'b1);
      for (int i = 0; i < 300; i++) begin
        logic [1:0] oen;
        oen = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
        step(1'b0, 3'(mm), iv, 6'($urandom), 2'($urandom), 1'($urandom),
             oen, tag_of(3'(mm), oen), 1'b1);
      end
      sweep(3'(mm), iv, tag_of(3'(mm), 2'b00));
    end
    // mixed random with occasional mode changes
    md = 3'd2;
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] oen;
      logic       w;
      if ($urandom % 40 == 0) md = 3'($urandom);
      oen = 2'($urandom);
      w   = ($urandom % 3 != 0);
      step(1'b0, md, {$urandom, $urandom}, 6'($urandom), 2'($urandom), w, oen,
           (eff(md) != mq) ? "R9" : (w ? tag_of(mq, oen) : "R7"), 1'b1);
    end
    summary();
  end

endmodule